// File: doc/BRIEF.md
# Call and Interrupt Stack Sequencer

This block carries out the stack traffic of a 16-bit processor core for subroutine calls, software interrupts, their returns, and single-register saves and restores. It holds a 16-bit stack pointer and a 16-bit stack segment. The stack lives in a 20-bit byte-addressed memory at segment times sixteen plus pointer. The stack grows toward lower addresses. Every word pushed moves the pointer down by two before the write. Every word popped is read first, and the pointer then moves up by two.

The core offers a command together with the operand words it may need: return offset, code segment, flag word or register value. The block then runs one, two or three word transfers on a request/acknowledge memory port. When the last transfer completes it pulses `done`. For return-type commands it presents the popped words at that point, in the order they left the stack. A pop never writes memory. Only the pointer moves, so the old words stay where they were. A load port sets the pointer and segment while the block is idle.

Top module: `callstack_seq`

## Requirements
- R1: After reset `cur_sp` and `cur_ss` are 0, `busy`, `done` and `mem_req` are low, and `cmd_ready` is high.
- R2: Every memory access uses address (`cur_ss` * 16 + SP) modulo 2^20. SP is the pointer value after the decrement for a push, and the current pointer for a pop.
- R3: Each written word first lowers the pointer by 2 and is stored at the new address. Command code 0 pushes `op_val`.
- R4: Each read word comes from the current address, and the pointer then rises by 2. Command code 1 pops one word to `res_w0`.
- R5: Command code 2 (near call) writes `op_ip` only. Command code 3 (far call) writes `op_cs`, then `op_ip`.
- R6: Command code 4 (interrupt entry) writes `op_flags`, then `op_cs`, then `op_ip`, at falling addresses.
- R7: Command code 5 (near return) pops one word to `res_w0`. Command code 6 (far return) pops the offset to `res_w0`, then the segment to `res_w1`. Command code 7 (interrupt return) pops offset, segment and flags to `res_w0`, `res_w1` and `res_w2`. Result slots not popped read 0.
- R8: The pointer wraps modulo 2^16 in both directions, and nothing flags the wrap.
- R9: `cmd_ready` is high only when `busy` and `ld_en` are both low. A command is taken when `cmd_valid` and `cmd_ready` are both high. `busy` is high from the next cycle until the sequence ends. Commands offered while busy cause no access.
- R10: `done` pulses for one cycle, in the cycle after the final transfer, with `busy` already low. Results hold until the next `done`. Pops write nothing, so a word popped twice reads the same.
- R11: `mem_req` is held high, with address, direction and write data stable, until `mem_ack` is seen. A transfer completes on a clock edge where `mem_req` and `mem_ack` are both high. Read data is taken on that edge.
- R12: `ld_en` while idle loads `ld_sp` and `ld_ss` on the next edge. `ld_en` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken |
| cmd_code | input | 3 | Command code (see R3 to R7) |
| op_ip | input | 16 | Return offset operand |
| op_cs | input | 16 | Code segment operand |
| op_flags | input | 16 | Flag word operand |
| op_val | input | 16 | Register value for a single push |
| ld_en | input | 1 | Load pointer and segment |
| ld_sp | input | 16 | Pointer value to load |
| ld_ss | input | 16 | Segment value to load |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 20 | Byte address of the word |
| mem_wdata | output | 16 | Write data |
| mem_ack | input | 1 | Memory accepts the transfer |
| mem_rdata | input | 16 | Read data, valid with `mem_ack` |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| res_w0 | output | 16 | First popped word |
| res_w1 | output | 16 | Second popped word |
| res_w2 | output | 16 | Third popped word |
| cur_sp | output | 16 | Stack pointer |
| cur_ss | output | 16 | Stack segment |

## Verification
The bench checks the order of the three-word interrupt frame and of its return. A design that swapped the segment and offset would hand back a return address built from the wrong halves. It drives the pointer across zero with a segment of FFFF. Here the 20-bit sum must wrap: a design that ignored the carry, or that wrote before decrementing, would hit the wrong word. The memory is throttled so that request hold and read capture are tested under back-pressure. A design that advanced early would skip or repeat words. The bench also offers commands and loads while a sequence is running, where any leak shows up as an extra access or a moved pointer. It pops the same word twice, which would reveal a pop that clears memory.

// File: rtl/callstack_pkg.sv
package callstack_pkg;
  localparam int STK_MAXW = 3;

  typedef enum logic [2:0] {
    CMD_PUSH      = 3'd0,
    CMD_POP       = 3'd1,
    CMD_CALL_NEAR = 3'd2,
    CMD_CALL_FAR  = 3'd3,
    CMD_INT       = 3'd4,
    CMD_RET_NEAR  = 3'd5,
    CMD_RET_FAR   = 3'd6,
    CMD_IRET      = 3'd7
  } stk_cmd_e;

  typedef enum logic {ST_IDLE = 1'b0, ST_XFER = 1'b1} stk_state_e;
endpackage

// File: rtl/callstack_decode.sv
module callstack_decode
  import callstack_pkg::*;
#(
  parameter int W = 16
) (
  input  stk_cmd_e                     cmd,
  input  logic [W-1:0]                 ip,
  input  logic [W-1:0]                 cs,
  input  logic [W-1:0]                 flags,
  input  logic [W-1:0]                 val,
  output logic                         is_pop,
  output logic [1:0]                   nwords,
  output logic [STK_MAXW-1:0][W-1:0]   slots
);
  // slots[0] is written first; far frames put the segment above the offset
  always_comb begin
    is_pop = 1'b0;
    nwords = 2'd1;
    slots  = '0;
    unique case (cmd)
      CMD_PUSH:      slots[0] = val;
      CMD_POP:       is_pop = 1'b1;
      CMD_CALL_NEAR: slots[0] = ip;
      CMD_CALL_FAR: begin
        nwords   = 2'd2;
        slots[0] = cs;
        slots[1] = ip;
      end
      CMD_INT: begin
        nwords   = 2'd3;
        slots[0] = flags;
        slots[1] = cs;
        slots[2] = ip;
      end
      CMD_RET_NEAR:  is_pop = 1'b1;
      CMD_RET_FAR: begin
        is_pop = 1'b1;
        nwords = 2'd2;
      end
      CMD_IRET: begin
        is_pop = 1'b1;
        nwords = 2'd3;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/callstack_addr.sv
module callstack_addr #(
  parameter int W      = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  parameter int STEP   = 2
) (
  input  logic [W-1:0]      ss,
  input  logic [W-1:0]      sp,
  input  logic              is_pop,
  output logic [ADDR_W-1:0] addr
);
  logic [W-1:0]      off;
  logic [ADDR_W-1:0] base;

  // a write targets the already-decremented pointer
  assign off  = is_pop ? sp : sp - W'(STEP);
  assign base = ADDR_W'({ss, {SHIFT{1'b0}}});
  assign addr = base + ADDR_W'(off);
endmodule

// File: rtl/callstack_ptr.sv
module callstack_ptr #(
  parameter int W    = 16,
  parameter int STEP = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_sp,
  input  logic [W-1:0] load_ss,
  input  logic         step_en,
  input  logic         step_up,
  output logic [W-1:0] sp,
  output logic [W-1:0] ss
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sp <= '0;
      ss <= '0;
    end else if (load) begin
      sp <= load_sp;
      ss <= load_ss;
    end else if (step_en) begin
      sp <= step_up ? sp + W'(STEP) : sp - W'(STEP);
    end
  end
endmodule

// File: rtl/callstack_seq.sv
module callstack_seq
  import callstack_pkg::*;
#(
  parameter int W      = 16,
  parameter int SHIFT  = 4,
  parameter int ADDR_W = 20,
  parameter int STEP   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_code,
  input  logic [W-1:0]      op_ip,
  input  logic [W-1:0]      op_cs,
  input  logic [W-1:0]      op_flags,
  input  logic [W-1:0]      op_val,
  input  logic              ld_en,
  input  logic [W-1:0]      ld_sp,
  input  logic [W-1:0]      ld_ss,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [W-1:0]      mem_wdata,
  input  logic              mem_ack,
  input  logic [W-1:0]      mem_rdata,
  output logic              busy,
  output logic              done,
  output logic [W-1:0]      res_w0,
  output logic [W-1:0]      res_w1,
  output logic [W-1:0]      res_w2,
  output logic [W-1:0]      cur_sp,
  output logic [W-1:0]      cur_ss
);
  localparam int CNT_W = $clog2(STK_MAXW + 1);

  stk_state_e                    state_q;
  logic [CNT_W-1:0]              idx_q;
  logic [CNT_W-1:0]              n_q;
  logic                          pop_q;
  logic [STK_MAXW-1:0][W-1:0]    slots_q;
  logic [W-1:0]                  cap_q [STK_MAXW];
  logic [W-1:0]                  res_q [STK_MAXW];
  logic                          done_q;

  logic                          dec_pop;
  logic [1:0]                    dec_n;
  logic [STK_MAXW-1:0][W-1:0]    dec_slots;
  logic                          accept;
  logic                          beat;
  logic                          last_beat;

  callstack_decode #(.W(W)) u_decode (
    .cmd    (stk_cmd_e'(cmd_code)),
    .ip     (op_ip),
    .cs     (op_cs),
    .flags  (op_flags),
    .val    (op_val),
    .is_pop (dec_pop),
    .nwords (dec_n),
    .slots  (dec_slots)
  );

  callstack_ptr #(.W(W), .STEP(STEP)) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (ld_en && !busy),
    .load_sp (ld_sp),
    .load_ss (ld_ss),
    .step_en (beat),
    .step_up (pop_q),
    .sp      (cur_sp),
    .ss      (cur_ss)
  );

  callstack_addr #(.W(W), .SHIFT(SHIFT), .ADDR_W(ADDR_W), .STEP(STEP)) u_addr (
    .ss     (cur_ss),
    .sp     (cur_sp),
    .is_pop (pop_q),
    .addr   (mem_addr)
  );

  assign busy      = (state_q == ST_XFER);
  assign cmd_ready = !busy && !ld_en;
  assign accept    = cmd_valid && cmd_ready;
  assign beat      = busy && mem_ack;
  assign last_beat = beat && (CNT_W'(idx_q + 1'b1) == n_q);

  assign mem_req   = busy;
  assign mem_we    = busy && !pop_q;
  assign mem_wdata = slots_q[idx_q];

  assign done   = done_q;
  assign res_w0 = res_q[0];
  assign res_w1 = res_q[1];
  assign res_w2 = res_q[2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      n_q     <= '0;
      pop_q   <= 1'b0;
      slots_q <= '0;
      done_q  <= 1'b0;
      for (int k = 0; k < STK_MAXW; k++) begin
        cap_q[k] <= '0;
        res_q[k] <= '0;
      end
    end else begin
      done_q <= last_beat;
      if (accept) begin
        state_q <= ST_XFER;
        idx_q   <= '0;
        n_q     <= CNT_W'(dec_n);
        pop_q   <= dec_pop;
        slots_q <= dec_slots;
        for (int k = 0; k < STK_MAXW; k++) cap_q[k] <= '0;
      end else if (beat) begin
        idx_q <= idx_q + 1'b1;
        if (pop_q) cap_q[idx_q] <= mem_rdata;
        if (last_beat) begin
          state_q <= ST_IDLE;
          for (int k = 0; k < STK_MAXW; k++)
            res_q[k] <= (pop_q && idx_q == CNT_W'(k)) ? mem_rdata : cap_q[k];
        end
      end
    end
  end

  // R11: request and its payload are held until acknowledged
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

  // R3: a completed write leaves the pointer two lower
  p_push_dec_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && mem_we |=> cur_sp == $past(cur_sp) - W'(STEP));

  // R4: a completed read leaves the pointer two higher
  p_pop_inc_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_ack && !mem_we |=> cur_sp == $past(cur_sp) + W'(STEP));

  // R9: a taken command makes the block busy
  p_accept_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> busy);

  // R10: done is a single pulse seen while idle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && !mem_req);

  // R12: a load while busy leaves the segment alone
  p_ld_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en && busy |=> $stable(cur_ss));
endmodule

// File: tb/test_callstack_seq.sv
module test_callstack_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [2:0]  cmd_code = '0;
  logic [15:0] op_ip = '0, op_cs = '0, op_flags = '0, op_val = '0;
  logic        ld_en = 1'b0;
  logic [15:0] ld_sp = '0, ld_ss = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [19:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;
  logic        busy, done;
  logic [15:0] res_w0, res_w1, res_w2, cur_sp, cur_ss;

  always #5 clk = ~clk;

  callstack_seq i_callstack_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_code(cmd_code), .op_ip(op_ip), .op_cs(op_cs), .op_flags(op_flags),
    .op_val(op_val), .ld_en(ld_en), .ld_sp(ld_sp), .ld_ss(ld_ss),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .busy(busy), .done(done),
    .res_w0(res_w0), .res_w1(res_w1), .res_w2(res_w2), .cur_sp(cur_sp), .cur_ss(cur_ss)
  );

  typedef struct { logic we; logic [19:0] addr; logic [15:0] data; string tag; } acc_t;
  typedef struct { logic [15:0] w0; logic [15:0] w1; logic [15:0] w2; string tag; } res_t;

  acc_t        acc_q[$];
  res_t        res_q[$];
  logic [15:0] shadow [int];
  logic [15:0] mem_m  [int];
  logic [15:0] sp_m = '0, ss_m = '0;
  int          checks = 0, failures = 0, done_seen = 0;
  logic        stall = 1'b0;
  logic [31:0] cyc = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [19:0] addr_of(input logic [15:0] ss, input logic [15:0] sp);
    logic [19:0] a;
    a = {ss, 4'h0} + {4'h0, sp};
    return a;
  endfunction

  // memory model: acknowledges one cycle after request, throttled when stalling
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) mem_ack <= 1'b0;
    else begin
      if (mem_req && mem_ack && mem_we) mem_m[int'(mem_addr)] = mem_wdata;
      mem_ack <= mem_req && !mem_ack && (!stall || cyc[1:0] == 2'd0);
    end
  end
  always @(negedge clk)
    mem_rdata = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 16'hDEAD;

  // monitor
  always @(negedge clk) begin
    if (rst_n && mem_req && mem_ack) begin
      if (acc_q.size() == 0) chk(1'b0, "R9", "unexpected access addr", 32'(mem_addr), 32'h0);
      else begin
        acc_t e;
        e = acc_q.pop_front();
        chk(mem_we == e.we, e.tag, "direction", 32'(mem_we), 32'(e.we));
        chk(mem_addr == e.addr, "R2", {e.tag, " address"}, 32'(mem_addr), 32'(e.addr));
        if (e.we) chk(mem_wdata == e.data, e.tag, "write data", 32'(mem_wdata), 32'(e.data));
      end
    end
    if (rst_n && done) begin
      done_seen++;
      if (res_q.size() == 0) chk(1'b0, "R10", "unexpected done", 32'h1, 32'h0);
      else begin
        res_t r;
        r = res_q.pop_front();
        chk(res_w0 == r.w0, r.tag, "res_w0", 32'(res_w0), 32'(r.w0));
        chk(res_w1 == r.w1, r.tag, "res_w1", 32'(res_w1), 32'(r.w1));
        chk(res_w2 == r.w2, r.tag, "res_w2", 32'(res_w2), 32'(r.w2));
        chk(!busy, "R10", "busy at done", 32'(busy), 32'h0);
      end
    end
  end

  // driver side: predict accesses and results from the requirements
  task automatic model_cmd(input logic [2:0] c, input logic [15:0] ip, input logic [15:0] cs,
                           input logic [15:0] fl, input logic [15:0] v, input string tag);
    logic [15:0] wl [3];
    int          n;
    bit          pop;
    res_t        r;
    pop = 1'b0; n = 1;
    case (c)
      3'd0: wl[0] = v;
      3'd1: pop = 1'b1;
      3'd2: wl[0] = ip;
      3'd3: begin n = 2; wl[0] = cs; wl[1] = ip; end
      3'd4: begin n = 3; wl[0] = fl; wl[1] = cs; wl[2] = ip; end
      3'd5: pop = 1'b1;
      3'd6: begin pop = 1'b1; n = 2; end
      default: begin pop = 1'b1; n = 3; end
    endcase
    r.w0 = '0; r.w1 = '0; r.w2 = '0; r.tag = tag;
    for (int i = 0; i < n; i++) begin
      acc_t e;
      e.tag = tag;
      if (!pop) begin
        sp_m = sp_m - 16'd2;
        e.we = 1'b1; e.addr = addr_of(ss_m, sp_m); e.data = wl[i];
        shadow[int'(e.addr)] = wl[i];
      end else begin
        logic [15:0] d;
        e.we = 1'b0; e.addr = addr_of(ss_m, sp_m); e.data = '0;
        d = shadow.exists(int'(e.addr)) ? shadow[int'(e.addr)] : 16'hDEAD;
        if (i == 0) r.w0 = d; else if (i == 1) r.w1 = d; else r.w2 = d;
        sp_m = sp_m + 16'd2;
      end
      acc_q.push_back(e);
    end
    res_q.push_back(r);
  endtask

  task automatic send(input logic [2:0] c, input logic [15:0] ip, input logic [15:0] cs,
                      input logic [15:0] fl, input logic [15:0] v);
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    cmd_code = c; op_ip = ip; op_cs = cs; op_flags = fl; op_val = v; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input int target, input string tag);
    while (done_seen < target) @(posedge clk);
    @(negedge clk);
    chk(cur_sp == sp_m, tag, "pointer after sequence", 32'(cur_sp), 32'(sp_m));
    chk(acc_q.size() == 0, tag, "accesses left over", 32'(acc_q.size()), 32'h0);
  endtask

  task automatic run(input logic [2:0] c, input logic [15:0] ip, input logic [15:0] cs,
                     input logic [15:0] fl, input logic [15:0] v, input string tag);
    int t;
    t = done_seen + 1;
    model_cmd(c, ip, cs, fl, v, tag);
    send(c, ip, cs, fl, v);
    wait_done(t, tag);
  endtask

  task automatic load(input logic [15:0] sp, input logic [15:0] ss);
    @(negedge clk);
    ld_en = 1'b1; ld_sp = sp; ld_ss = ss;
    @(negedge clk);
    ld_en = 1'b0;
    sp_m = sp; ss_m = ss;
    chk(cur_sp == sp, "R12", "loaded pointer", 32'(cur_sp), 32'(sp));
    chk(cur_ss == ss, "R12", "loaded segment", 32'(cur_ss), 32'(ss));
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R9", "watchdog expired", 32'h0, 32'h1);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cur_sp == 16'h0, "R1", "sp after reset", 32'(cur_sp), 32'h0);
    chk(cur_ss == 16'h0, "R1", "ss after reset", 32'(cur_ss), 32'h0);
    chk(!busy && !done && !mem_req, "R1", "idle outputs", {29'h0, busy, done, mem_req}, 32'h0);
    chk(cmd_ready, "R1", "ready after reset", 32'(cmd_ready), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    load(16'h0100, 16'h1B37);
    // nested frames then unwind in reverse
    run(3'd0, '0, '0, '0, 16'h1234, "R3");
    run(3'd2, 16'h5555, '0, '0, '0, "R5");
    run(3'd3, 16'h3333, 16'h2222, '0, '0, "R5");
    run(3'd4, 16'h6666, 16'h4444, 16'h0202, '0, "R6");
    run(3'd7, '0, '0, '0, '0, "R7");
    run(3'd6, '0, '0, '0, '0, "R7");
    run(3'd5, '0, '0, '0, '0, "R7");
    run(3'd1, '0, '0, '0, '0, "R4");
    chk(cur_sp == 16'h0100, "R4", "pointer back to start", 32'(cur_sp), 32'h0100);

    // R11 back-pressure
    stall = 1'b1;
    run(3'd4, 16'hA1A1, 16'hB2B2, 16'hC3C3, '0, "R11");
    run(3'd7, '0, '0, '0, '0, "R11");
    run(3'd3, 16'h0F0F, 16'hF0F0, '0, '0, "R11");
    run(3'd6, '0, '0, '0, '0, "R11");
    stall = 1'b0;

    // R8 wrap of pointer and of 20-bit address
    load(16'h0000, 16'hFFFF);
    run(3'd0, '0, '0, '0, 16'hAAAA, "R8");
    chk(cur_sp == 16'hFFFE, "R8", "pointer wrapped down", 32'(cur_sp), 32'hFFFE);
    run(3'd1, '0, '0, '0, '0, "R8");
    chk(cur_sp == 16'h0000, "R8", "pointer wrapped up", 32'(cur_sp), 32'h0);

    // R10 popping leaves memory intact
    load(16'h2000, 16'h1490);
    run(3'd0, '0, '0, '0, 16'hBEEF, "R10");
    run(3'd1, '0, '0, '0, '0, "R10");
    load(16'h1FFE, 16'h1490);
    run(3'd1, '0, '0, '0, '0, "R10");
    chk(res_w0 == 16'hBEEF && res_w1 == 16'h0, "R10", "results held after done", 32'(res_w0), 32'hBEEF);

    // R9 and R12: commands and loads offered while busy
    stall = 1'b1;
    begin
      int t;
      t = done_seen + 1;
      model_cmd(3'd4, 16'h1111, 16'h2222, 16'h3333, '0, "R9");
      send(3'd4, 16'h1111, 16'h2222, 16'h3333, '0);
      chk(busy, "R9", "busy after accept", 32'(busy), 32'h1);
      chk(!cmd_ready, "R9", "ready while busy", 32'(cmd_ready), 32'h0);
      cmd_code = 3'd1; cmd_valid = 1'b1;
      ld_en = 1'b1; ld_sp = 16'h7777; ld_ss = 16'h5555;
      @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0; ld_en = 1'b0;
      wait_done(t, "R12");
      chk(cur_ss == ss_m, "R12", "segment untouched by busy load", 32'(cur_ss), 32'(ss_m));
      repeat (3) @(negedge clk);
      chk(!busy && !mem_req, "R9", "no extra sequence", {30'h0, busy, mem_req}, 32'h0);
    end
    stall = 1'b0;
    run(3'd7, '0, '0, '0, '0, "R7");

    summary();
    $finish;
  end
endmodule